// File: doc/BRIEF.md
# Power Mode and Reset Controller

This block governs the reduced-activity states of a small 8-bit microcontroller and decides when the external reset pin has been held long enough to count as a real reset. Software writes an 8-bit mode register over a plain write strobe and reads it back at any time. From that register the block derives three clock enables: one for the CPU, one for the peripheral group (timers, serial port, interrupt logic) and one for the oscillator. It also exports the baud-doubling bit to the baud generator.

There are two low-power states. The light one stops only the CPU and ends when an interrupt is pending. The deep one stops the oscillator, and with it everything else except stored state. Only a reset ends it. Because no clock is available in the deep state, the pin is then allowed straight through to the reset output without filtering. In every other state the pin must stay high for two full machine cycles of oscillator clocks before the reset output rises.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: The mode register holds the baud-double flag in bit 7, two free software flags in bits 3:2, the deep-sleep request in bit 1 and the light-sleep request in bit 0. Bits 6:4 ignore writes and read as 0. Bit 7 drives `baud_double`.
- R2: After `rst`, the register reads 0x00, all three clock enables are 1, `baud_double` is 0 and `sys_rst` is 0 once `rst` has fallen.
- R3: While bit 0 is set, `cpu_clk_en` is 0 and `per_clk_en` and `osc_en` stay 1.
- R4: A clock edge that sees `irq_pending` high clears bit 0. This also applies on the edge of a write that sets bit 0, so the light state is never entered.
- R5: While bit 1 is set and the pin is low, all three clock enables are 0.
- R6: `irq_pending` does not clear bit 1.
- R7: A write with both bits 1 and 0 set stores bit 1 only, so the register reads bit1:0 = 2'b10.
- R8: Outside the deep state, `sys_rst` rises only after 24 consecutive high clock samples of `rst_pin` (2 machine cycles of 12 clocks). It rises two clocks after the 24th sample. A run of 23 samples produces no reset.
- R9: A clock edge that sees `sys_rst` high clears the whole register to 0x00, overriding any write.
- R10: In the deep state, a high `rst_pin` drives `sys_rst` and `osc_en` high with no clock edge. The register then reads 0x00 after the next clock edge.
- R11: The software flags in bits 3:2 change no clock enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous power-on reset, active high |
| rst_pin | input | 1 | External reset pin, asynchronous, active high |
| irq_pending | input | 1 | An enabled interrupt is pending (wake source for the light state) |
| pcon_we | input | 1 | Write strobe for the mode register |
| pcon_wdata | input | 8 | Write data for the mode register |
| pcon_rdata | output | 8 | Mode register read value |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator enable |
| baud_double | output | 1 | Baud-doubling flag for the baud generator |
| sys_rst | output | 1 | Qualified system reset |

## Verification
The bench builds the block with its default parameters: 12 clocks per machine cycle, 2 machine cycles to qualify a reset, and 2 synchronizer stages. With these values the 24-sample threshold can be reached directly. Pulses of 23 and 24 samples land on either side of it, and the two-clock delay through the synchronizer falls inside a short observation window. The same small threshold lets a deep-sleep wake be tried with a pin pulse far too short for the filter. This shows that the bypass path, and not the counter, produced the reset.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    localparam int REG_W     = 8;
    localparam int BIT_IDLE  = 0;
    localparam int BIT_PD    = 1;
    localparam int BIT_GP_LO = 2;
    localparam int BIT_GP_HI = 3;
    localparam int BIT_BAUD  = 7;

    // Mode register image; field order fixes the bit positions software sees.
    typedef struct packed {
        logic       baud;
        logic [2:0] rsvd;
        logic [1:0] gp;
        logic       pd;
        logic       idle;
    } pcon_t;

    typedef struct packed {
        logic cpu;
        logic per;
        logic osc;
    } clk_en_t;

    localparam pcon_t PCON_RESET = '0;

    // Register value after a software write: reserved bits dropped,
    // deep sleep wins over light sleep when both are requested.
    function automatic pcon_t pcon_apply_write(logic [REG_W-1:0] d);
        pcon_t w;
        w      = d;
        w.rsvd = '0;
        w.idle = w.idle & ~w.pd;
        return w;
    endfunction

    function automatic logic [REG_W-1:0] pcon_read(pcon_t r);
        pcon_t v;
        v      = r;
        v.rsvd = '0;
        return v;
    endfunction

    function automatic int filt_threshold(int clks_per_mc, int mcs);
        return clks_per_mc * mcs;
    endfunction

endpackage

// File: rtl/pmc_rst_filter.sv
module pmc_rst_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int THRESH      = 24
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic qualified
);
    localparam int CNT_W = $clog2(THRESH + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(THRESH);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CNT_W-1:0]       run_q;
    logic                   sampled;

    generate
        if (SYNC_STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= pin;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
            end
        end
    endgenerate

    assign sampled = sync_q[SYNC_STAGES-1];

    // Consecutive-high counter: any low sample restarts it, it parks at the limit.
    always_ff @(posedge clk) begin
        if (rst)                 run_q <= '0;
        else if (!sampled)       run_q <= '0;
        else if (run_q != CNT_MAX) run_q <= run_q + CNT_W'(1);
    end

    assign qualified = (run_q == CNT_MAX);

endmodule

// File: rtl/pmc_ctrl_reg.sv
module pmc_ctrl_reg
    import pmc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    input  logic             irq_pending,
    input  logic             pin,
    output pcon_t            q,
    output logic             wake_hold
);
    pcon_t nxt;
    logic  hold_nxt;

    always_comb begin
        nxt = q;
        if (we)          nxt = pcon_apply_write(wdata);
        if (irq_pending) nxt.idle = 1'b0;
    end

    // The wake marker outlives the register clear so a pin-driven wake
    // keeps reset asserted for as long as the pin stays high.
    always_comb begin
        hold_nxt = wake_hold;
        if (we && wdata[BIT_PD] && !clr) hold_nxt = 1'b1;
        else if (!q.pd && !pin)          hold_nxt = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (clr) q <= PCON_RESET;
        else     q <= nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) wake_hold <= 1'b0;
        else     wake_hold <= hold_nxt;
    end

endmodule

// File: rtl/pmc_clk_gate.sv
module pmc_clk_gate
    import pmc_pkg::*;
(
    input  logic    idle,
    input  logic    pd,
    input  logic    wake,
    output clk_en_t en
);
    always_comb begin
        en.osc = !pd || wake;
        en.per = en.osc;
        en.cpu = en.per && !idle;
    end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pmc_pkg::*;
#(
    parameter int CLKS_PER_MC = 12,
    parameter int RST_MCS     = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rst_pin,
    input  logic       irq_pending,
    input  logic       pcon_we,
    input  logic [7:0] pcon_wdata,
    output logic [7:0] pcon_rdata,
    output logic       cpu_clk_en,
    output logic       per_clk_en,
    output logic       osc_en,
    output logic       baud_double,
    output logic       sys_rst
);
    localparam int RST_THRESH = filt_threshold(CLKS_PER_MC, RST_MCS);

    pcon_t   pcon_q;
    clk_en_t en;
    logic    filt_rst;
    logic    wake_hold;
    logic    wake;

    pmc_rst_filter #(
        .SYNC_STAGES (SYNC_STAGES),
        .THRESH      (RST_THRESH)
    ) u_filter (
        .clk       (clk),
        .rst       (rst),
        .pin       (rst_pin),
        .qualified (filt_rst)
    );

    // Deep-sleep bypass: no clock runs, so the raw pin is the reset.
    assign wake    = wake_hold && rst_pin;
    assign sys_rst = rst || filt_rst || wake;

    pmc_ctrl_reg u_reg (
        .clk         (clk),
        .rst         (rst),
        .clr         (sys_rst),
        .we          (pcon_we),
        .wdata       (pcon_wdata),
        .irq_pending (irq_pending),
        .pin         (rst_pin),
        .q           (pcon_q),
        .wake_hold   (wake_hold)
    );

    pmc_clk_gate u_gate (
        .idle (pcon_q.idle),
        .pd   (pcon_q.pd),
        .wake (wake),
        .en   (en)
    );

    assign pcon_rdata  = pcon_read(pcon_q);
    assign baud_double = pcon_q.baud;
    assign cpu_clk_en  = en.cpu;
    assign per_clk_en  = en.per;
    assign osc_en      = en.osc;

endmodule

// File: rtl/pmc_checker.sv
module pmc_checker #(
    parameter int THRESH = 24
) (
    input logic       clk,
    input logic       rst,
    input logic       rst_pin,
    input logic       irq_pending,
    input logic       pcon_we,
    input logic [1:0] wdata_mode,
    input logic [7:0] pcon_rdata,
    input logic       cpu_clk_en,
    input logic       per_clk_en,
    input logic       osc_en,
    input logic       sys_rst,
    input logic       wake_hold
);
    localparam int W = $clog2(THRESH + 1);
    localparam logic [W-1:0] LIM = W'(THRESH);

    logic [W-1:0] run_q;
    logic [W-1:0] peak_q;

    // Longest run of high pin samples since reset was last seen.
    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= '0;
            peak_q <= '0;
        end else begin
            run_q  <= rst_pin ? ((run_q == LIM) ? run_q : run_q + W'(1)) : '0;
            peak_q <= sys_rst ? '0 : ((run_q > peak_q) ? run_q : peak_q);
        end
    end

    p_idle_cpu_only_r3: assert property (@(posedge clk) disable iff (rst)
        pcon_rdata[0] |-> !cpu_clk_en && per_clk_en && osc_en);

    p_idle_wake_r4: assert property (@(posedge clk) disable iff (rst)
        pcon_rdata[0] && irq_pending && !sys_rst |=> !pcon_rdata[0]);

    p_pd_gates_all_r5: assert property (@(posedge clk) disable iff (rst)
        pcon_rdata[1] && !rst_pin |-> !osc_en && !per_clk_en && !cpu_clk_en);

    p_pd_keeps_r6: assert property (@(posedge clk) disable iff (rst)
        pcon_rdata[1] && irq_pending && !pcon_we && !sys_rst |=> pcon_rdata[1]);

    p_pd_priority_r7: assert property (@(posedge clk) disable iff (rst)
        pcon_we && wdata_mode == 2'b11 && !sys_rst |=> pcon_rdata[1:0] == 2'b10);

    p_rst_needs_run_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(sys_rst) && !wake_hold |-> peak_q >= LIM);

    p_rst_clears_r9: assert property (@(posedge clk) disable iff (rst)
        sys_rst |=> pcon_rdata == 8'h00);

    p_wake_async_r10: assert property (@(posedge clk) disable iff (rst)
        wake_hold && rst_pin |-> sys_rst && osc_en);

endmodule

bind pwr_mode_ctrl pmc_checker #(.THRESH(RST_THRESH)) u_pmc_checker (
    .clk         (clk),
    .rst         (rst),
    .rst_pin     (rst_pin),
    .irq_pending (irq_pending),
    .pcon_we     (pcon_we),
    .wdata_mode  (pcon_wdata[1:0]),
    .pcon_rdata  (pcon_rdata),
    .cpu_clk_en  (cpu_clk_en),
    .per_clk_en  (per_clk_en),
    .osc_en      (osc_en),
    .sys_rst     (sys_rst),
    .wake_hold   (wake_hold)
);

// File: tb/pwr_mode_ctrl_bench.sv
module pwr_mode_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic       rst_pin;
    logic       irq_pending;
    logic       pcon_we;
    logic [7:0] pcon_wdata;
    logic [7:0] pcon_rdata;
    logic       cpu_clk_en, per_clk_en, osc_en, baud_double, sys_rst;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    pwr_mode_ctrl u_pwr_mode_ctrl (
        .clk         (clk),
        .rst         (rst),
        .rst_pin     (rst_pin),
        .irq_pending (irq_pending),
        .pcon_we     (pcon_we),
        .pcon_wdata  (pcon_wdata),
        .pcon_rdata  (pcon_rdata),
        .cpu_clk_en  (cpu_clk_en),
        .per_clk_en  (per_clk_en),
        .osc_en      (osc_en),
        .baud_double (baud_double),
        .sys_rst     (sys_rst)
    );

    // Expected register after one edge, from R1, R4 and R7.
    function automatic logic [7:0] model_next(logic [7:0] cur, logic we, logic [7:0] d, logic irq);
        logic [7:0] n;
        n = cur;
        if (we) n = {d[7], 3'b000, d[3:2], d[1], d[0] & ~d[1]};
        if (irq) n[0] = 1'b0;
        return n;
    endfunction

    // Expected {cpu, per, osc} from R3, R5, R11 with the pin low.
    function automatic logic [2:0] model_en(logic [7:0] r);
        if (r[1]) return 3'b000;
        if (r[0]) return 3'b011;
        return 3'b111;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] d, logic irq);
        pcon_we     = 1'b1;
        pcon_wdata  = d;
        irq_pending = irq;
        @(negedge clk);
        pcon_we     = 1'b0;
        irq_pending = 1'b0;
    endtask

    task automatic pin_pulse(int n, output bit seen);
        seen    = 1'b0;
        rst_pin = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            seen |= sys_rst;
        end
        rst_pin = 1'b0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            seen |= sys_rst;
        end
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] exp_reg;
        bit seen;
        void'($urandom(32'd20240611));
        rst = 1'b1; rst_pin = 1'b0; irq_pending = 1'b0;
        pcon_we = 1'b0; pcon_wdata = 8'h00;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R2 reset state
        check("R2 rdata", pcon_rdata, 8'h00);
        check("R2 enables", {cpu_clk_en, per_clk_en, osc_en}, 3'b111);
        check("R2 baud", baud_double, 1'b0);
        check("R2 sys_rst", sys_rst, 1'b0);

        // R1 reserved bits dropped, R11 flags leave enables alone
        wr(8'h7C, 1'b0);
        check("R1 reserved ignored", pcon_rdata, 8'h0C);
        check("R11 flags no effect", {cpu_clk_en, per_clk_en, osc_en}, 3'b111);
        wr(8'h80, 1'b0);
        check("R1 baud bit", baud_double, 1'b1);
        check("R1 readback", pcon_rdata, 8'h80);

        // R3 light state, R4 interrupt wake
        wr(8'h01, 1'b0);
        check("R3 rdata", pcon_rdata, 8'h01);
        check("R3 enables", {cpu_clk_en, per_clk_en, osc_en}, 3'b011);
        irq_pending = 1'b1;
        @(negedge clk);
        irq_pending = 1'b0;
        check("R4 idle cleared", pcon_rdata, 8'h00);
        check("R4 cpu resumes", cpu_clk_en, 1'b1);
        wr(8'h01, 1'b1);
        check("R4 irq during write", pcon_rdata, 8'h00);

        // Random mix, deep-sleep bit masked off
        exp_reg = pcon_rdata;
        for (int i = 0; i < 300; i++) begin
            logic       w;
            logic [7:0] d;
            logic       q;
            w = 1'($urandom % 2);
            d = 8'($urandom) & 8'hFD;
            q = ($urandom % 4) == 0;
            pcon_we = w; pcon_wdata = d; irq_pending = q;
            exp_reg = model_next(exp_reg, w, d, q);
            @(negedge clk);
            check("R1 R3 R4 random rdata", pcon_rdata, exp_reg);
            check("R3 R11 random enables", {cpu_clk_en, per_clk_en, osc_en}, model_en(exp_reg));
        end
        pcon_we = 1'b0; irq_pending = 1'b0;
        @(negedge clk);

        // R8 filter boundary
        wr(8'h8C, 1'b0);
        pin_pulse(23, seen);
        check("R8 23 samples no reset", seen, 1'b0);
        check("R8 register kept", pcon_rdata, 8'h8C);
        pin_pulse(24, seen);
        check("R8 24 samples reset", seen, 1'b1);
        check("R9 register cleared", pcon_rdata, 8'h00);
        check("R9 baud cleared", baud_double, 1'b0);

        // R7 priority, R5 deep state, R6 interrupt ignored
        wr(8'h83, 1'b0);
        check("R7 priority", pcon_rdata, 8'h82);
        check("R5 enables off", {cpu_clk_en, per_clk_en, osc_en}, 3'b000);
        irq_pending = 1'b1;
        repeat (5) @(negedge clk);
        irq_pending = 1'b0;
        check("R6 pd kept", pcon_rdata, 8'h82);
        check("R6 osc still off", osc_en, 1'b0);

        // R10 asynchronous wake
        rst_pin = 1'b1;
        #1;
        check("R10 sys_rst immediate", sys_rst, 1'b1);
        check("R10 osc immediate", osc_en, 1'b1);
        repeat (3) @(negedge clk);
        check("R10 register cleared", pcon_rdata, 8'h00);
        check("R10 reset held", sys_rst, 1'b1);
        rst_pin = 1'b0;
        #1;
        check("R10 reset released", sys_rst, 1'b0);
        @(negedge clk);
        check("R10 enables back", {cpu_clk_en, per_clk_en, osc_en}, 3'b111);
        wr(8'h01, 1'b0);
        check("R3 after wake", pcon_rdata, 8'h01);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule